// File: doc/BRIEF.md
# Engine Handle Binding Table

This block keeps track of a small pool of hardware engine resources and of the handle registers that software uses to name them. Each resource has a fixed 4-bit type code, set by a parameter. A handle is unbound, bound to one hardware resource, or bound to a software-emulated engine. The block serves one operation per cycle: acquire, release, save or rebind. It answers one cycle later with a 32-bit result, a fault flag and a flag that marks a software binding.

A saved binding is a 32-bit word. For a hardware resource the word holds the type code in bits 11:8 and the resource index in bits 7:1, and bit 0 is zero. Any word with bit 0 set stands for a software engine. The word is stored as given and is never checked against the pool. A hardware word that is handed back through rebind is checked against the live pool before it is accepted. The fault flag stands in for trap delivery. A faulting operation changes nothing.

Top module: `ehb_table`

## Requirements
- R1: After reset every handle is unbound, every resource is free, and result_o, fault_o and sw_o are 0. All outputs are registered and describe the operation presented one cycle earlier. The operation codes are 0 idle, 1 acquire, 2 release, 3 save and 4 rebind. Codes 5 to 7 act as idle, and an idle cycle returns result 0 with both flags 0.
- R2: A successful acquire binds the lowest-index free resource whose type code equals type_i. It returns the hardware word (type << 8) | (index << 1).
- R3: Acquire faults when no free resource of the requested type exists, or when the handle is already bound.
- R4: Release frees the resource held by the handle and unbinds the handle, returning result 0. Release of an unbound handle faults.
- R5: Save of a hardware binding returns its hardware word with bit 0 clear and sw_o low. Save of a software binding returns the stored word with sw_o high. Save of an unbound handle faults.
- R6: Rebind with value_i bit 0 set never faults. It binds the handle to that software word, echoes the word on result_o and raises sw_o.
- R7: Rebind with value_i bit 0 clear faults in three cases: the index field (bits 7:1) is 8 or more, the type field (bits 11:8) differs from that resource's type, or the resource is held by a different handle. Otherwise it binds the handle and returns the canonical hardware word. Rebinding a resource the same handle already holds is accepted.
- R8: A successful rebind replaces the handle's previous binding, and a hardware resource held before becomes free.
- R9: On a fault, result_o and sw_o are 0 and no binding or resource state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code |
| hnd_i | input | 2 | Handle register index |
| type_i | input | 4 | Requested resource type for acquire |
| value_i | input | 32 | Binding word for rebind |
| result_o | output | 32 | Result word of the previous operation |
| fault_o | output | 1 | Previous operation faulted |
| sw_o | output | 1 | Result refers to a software binding |

## Verification
On every cycle the assertions check three things. First, the ownership records of the handles and of the resources agree, so no resource is held twice or left orphaned. Second, a fault leaves the pool untouched and gives a quiet result. Third, acquire and save words carry the right type and a clear bit 0, and software rebinds always succeed. Some behaviour only the bench's ordered scenarios can show: choosing the lowest free index, a resource being reused after release or after a rebind moves away from it, and rejection for a foreign owner, a bad index or a type mismatch.

// File: rtl/ehb_pkg.sv
package ehb_pkg;
    localparam int TYPE_W   = 4;
    localparam int VAL_W    = 32;
    localparam int IDX_LSB  = 1;
    localparam int IDX_FW   = 7;
    localparam int TYPE_LSB = 8;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_ACQUIRE = 3'd1,
        OP_RELEASE = 3'd2,
        OP_SAVE    = 3'd3,
        OP_REBIND  = 3'd4
    } ehb_op_e;

    // Hardware binding word: type in 11:8, index in 7:1, bit 0 zero.
    function automatic logic [VAL_W-1:0] hw_word(input logic [IDX_FW-1:0] idx,
                                                 input logic [TYPE_W-1:0] typ);
        logic [VAL_W-1:0] w;
        w = '0;
        w[TYPE_LSB +: TYPE_W] = typ;
        w[IDX_LSB +: IDX_FW]  = idx;
        return w;
    endfunction
endpackage

// File: rtl/ehb_pick.sv
module ehb_pick #(
    parameter int NR = 8,
    parameter logic [NR*ehb_pkg::TYPE_W-1:0] RES_TYPES = '0,
    localparam int RIDX_W = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic [NR-1:0]               busy_i,
    input  logic [ehb_pkg::TYPE_W-1:0]  want_i,
    output logic                        hit_o,
    output logic [RIDX_W-1:0]           idx_o
);
    logic [NR-1:0] cand;

    for (genvar g = 0; g < NR; g++) begin : g_match
        assign cand[g] = !busy_i[g] &&
                         (RES_TYPES[g*ehb_pkg::TYPE_W +: ehb_pkg::TYPE_W] == want_i);
    end

    // Lowest index wins: scan downward so the last write is the lowest.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NR - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit_o = 1'b1;
                idx_o = RIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ehb_decode.sv
module ehb_decode #(
    parameter int NR = 8,
    parameter logic [NR*ehb_pkg::TYPE_W-1:0] RES_TYPES = '0,
    localparam int RIDX_W = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic [ehb_pkg::VAL_W-1:0]   word_i,
    output logic                        is_sw_o,
    output logic                        in_range_o,
    output logic [RIDX_W-1:0]           idx_o,
    output logic [ehb_pkg::TYPE_W-1:0]  fld_type_o,
    output logic [ehb_pkg::TYPE_W-1:0]  res_type_o
);
    import ehb_pkg::*;
    localparam logic [IDX_FW-1:0] NR_F = IDX_FW'(NR);

    logic [IDX_FW-1:0] fld_idx;

    assign is_sw_o    = word_i[0];
    assign fld_idx    = word_i[IDX_LSB +: IDX_FW];
    assign in_range_o = fld_idx < NR_F;
    assign idx_o      = fld_idx[RIDX_W-1:0];
    assign fld_type_o = word_i[TYPE_LSB +: TYPE_W];

    always_comb begin
        res_type_o = '0;
        for (int i = 0; i < NR; i++) begin
            if (in_range_o && idx_o == RIDX_W'(i)) begin
                res_type_o = RES_TYPES[i*TYPE_W +: TYPE_W];
            end
        end
    end
endmodule

// File: rtl/ehb_table.sv
module ehb_table #(
    parameter int NUM_RES     = 8,
    parameter int NUM_HANDLES = 4,
    parameter logic [NUM_RES*ehb_pkg::TYPE_W-1:0] RES_TYPES = 32'h5333_2211
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [2:0]                  op_i,
    input  logic [1:0]                  hnd_i,
    input  logic [ehb_pkg::TYPE_W-1:0]  type_i,
    input  logic [ehb_pkg::VAL_W-1:0]   value_i,
    output logic [ehb_pkg::VAL_W-1:0]   result_o,
    output logic                        fault_o,
    output logic                        sw_o
);
    import ehb_pkg::*;

    localparam int RIDX_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1;
    localparam int HIDX_W = (NUM_HANDLES > 1) ? $clog2(NUM_HANDLES) : 1;

    typedef struct packed {
        logic              bound;
        logic              sw;
        logic [RIDX_W-1:0] res;
        logic [VAL_W-1:0]  word;
    } hnd_t;

    typedef struct packed {
        logic [NUM_RES-1:0]                   busy;
        logic [NUM_RES-1:0][HIDX_W-1:0]       owner;
        hnd_t [NUM_HANDLES-1:0]               hnd;
        logic [VAL_W-1:0]                     result;
        logic                                 fault;
        logic                                 sw;
    } state_t;

    state_t st_d, st_q;

    logic [HIDX_W-1:0]  hsel;
    ehb_op_e            op;
    hnd_t               cur;
    logic               pick_hit;
    logic [RIDX_W-1:0]  pick_idx;
    logic               dec_sw, dec_in_range;
    logic [RIDX_W-1:0]  dec_idx;
    logic [TYPE_W-1:0]  dec_fld_type, dec_res_type;
    logic               hw_ok;

    assign hsel = HIDX_W'(hnd_i);
    assign op   = ehb_op_e'(op_i);
    assign cur  = st_q.hnd[hsel];

    function automatic logic [TYPE_W-1:0] type_of(input logic [RIDX_W-1:0] r);
        return RES_TYPES[r*TYPE_W +: TYPE_W];
    endfunction

    ehb_pick #(.NR(NUM_RES), .RES_TYPES(RES_TYPES)) u_pick (
        .busy_i (st_q.busy),
        .want_i (type_i),
        .hit_o  (pick_hit),
        .idx_o  (pick_idx)
    );

    ehb_decode #(.NR(NUM_RES), .RES_TYPES(RES_TYPES)) u_dec (
        .word_i     (value_i),
        .is_sw_o    (dec_sw),
        .in_range_o (dec_in_range),
        .idx_o      (dec_idx),
        .fld_type_o (dec_fld_type),
        .res_type_o (dec_res_type)
    );

    assign hw_ok = dec_in_range && (dec_fld_type == dec_res_type) &&
                   (!st_q.busy[dec_idx] || st_q.owner[dec_idx] == hsel);

    always_comb begin
        st_d        = st_q;
        st_d.result = '0;
        st_d.fault  = 1'b0;
        st_d.sw     = 1'b0;
        unique case (op)
            OP_ACQUIRE: begin
                if (cur.bound || !pick_hit) begin
                    st_d.fault = 1'b1;
                end else begin
                    st_d.busy[pick_idx]  = 1'b1;
                    st_d.owner[pick_idx] = hsel;
                    st_d.hnd[hsel]       = '{bound: 1'b1, sw: 1'b0, res: pick_idx, word: '0};
                    st_d.result          = hw_word(IDX_FW'(pick_idx), type_i);
                end
            end
            OP_RELEASE: begin
                if (!cur.bound) begin
                    st_d.fault = 1'b1;
                end else begin
                    if (!cur.sw) st_d.busy[cur.res] = 1'b0;
                    st_d.hnd[hsel] = '0;
                end
            end
            OP_SAVE: begin
                if (!cur.bound) begin
                    st_d.fault = 1'b1;
                end else if (cur.sw) begin
                    st_d.result = cur.word;
                    st_d.sw     = 1'b1;
                end else begin
                    st_d.result = hw_word(IDX_FW'(cur.res), type_of(cur.res));
                end
            end
            OP_REBIND: begin
                if (dec_sw) begin
                    if (cur.bound && !cur.sw) st_d.busy[cur.res] = 1'b0;
                    st_d.hnd[hsel] = '{bound: 1'b1, sw: 1'b1, res: '0, word: value_i};
                    st_d.result    = value_i;
                    st_d.sw        = 1'b1;
                end else if (!hw_ok) begin
                    st_d.fault = 1'b1;
                end else begin
                    if (cur.bound && !cur.sw) st_d.busy[cur.res] = 1'b0;
                    st_d.busy[dec_idx]  = 1'b1;
                    st_d.owner[dec_idx] = hsel;
                    st_d.hnd[hsel]      = '{bound: 1'b1, sw: 1'b0, res: dec_idx, word: '0};
                    st_d.result         = hw_word(IDX_FW'(dec_idx), dec_res_type);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign result_o = st_q.result;
    assign fault_o  = st_q.fault;
    assign sw_o     = st_q.sw;

    // Flattened views of the binding state for the bound checker.
    logic [NUM_RES-1:0]            chk_busy;
    logic [NUM_RES*HIDX_W-1:0]     chk_owner;
    logic [NUM_HANDLES-1:0]        chk_bound, chk_sw;
    logic [NUM_HANDLES*RIDX_W-1:0] chk_res;

    always_comb begin
        chk_busy = st_q.busy;
        for (int r = 0; r < NUM_RES; r++) chk_owner[r*HIDX_W +: HIDX_W] = st_q.owner[r];
        for (int h = 0; h < NUM_HANDLES; h++) begin
            chk_bound[h]                  = st_q.hnd[h].bound;
            chk_sw[h]                     = st_q.hnd[h].sw;
            chk_res[h*RIDX_W +: RIDX_W]   = st_q.hnd[h].res;
        end
    end
endmodule

// File: rtl/ehb_chk.sv
module ehb_chk #(
    parameter int NR = 8,
    parameter int NH = 4,
    localparam int RIDX_W = (NR > 1) ? $clog2(NR) : 1,
    localparam int HIDX_W = (NH > 1) ? $clog2(NH) : 1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [2:0]         op_i,
    input logic [3:0]         type_i,
    input logic [31:0]        value_i,
    input logic [31:0]        result_o,
    input logic               fault_o,
    input logic               sw_o,
    input logic [NR-1:0]      chk_busy,
    input logic [NR*HIDX_W-1:0] chk_owner,
    input logic [NH-1:0]      chk_bound,
    input logic [NH-1:0]      chk_sw,
    input logic [NH*RIDX_W-1:0] chk_res
);
    // R2
    acq_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(op_i) == 3'd1 && !fault_o) |-> (result_o[11:8] == $past(type_i) && !result_o[0] && !sw_o));

    // R5
    save_hw_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(op_i) == 3'd3 && !fault_o && !sw_o) |-> !result_o[0]);

    // R6
    sw_rebind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(op_i) == 3'd4 && $past(value_i[0])) |-> (!fault_o && sw_o && result_o == $past(value_i)));

    // R9
    fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (result_o == 32'd0 && !sw_o));

    // R9
    fault_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> ($stable(chk_busy) && $stable(chk_bound) && $stable(chk_res)));

    for (genvar h = 0; h < NH; h++) begin : g_hnd
        // R8
        hnd_owns_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (chk_bound[h] && !chk_sw[h]) |->
            (chk_busy[chk_res[h*RIDX_W +: RIDX_W]] &&
             chk_owner[chk_res[h*RIDX_W +: RIDX_W]*HIDX_W +: HIDX_W] == HIDX_W'(h)));
    end

    for (genvar r = 0; r < NR; r++) begin : g_res
        // R4
        res_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            chk_busy[r] |->
            (chk_bound[chk_owner[r*HIDX_W +: HIDX_W]] && !chk_sw[chk_owner[r*HIDX_W +: HIDX_W]] &&
             chk_res[chk_owner[r*HIDX_W +: HIDX_W]*RIDX_W +: RIDX_W] == RIDX_W'(r)));
    end
endmodule

bind ehb_table ehb_chk #(.NR(NUM_RES), .NH(NUM_HANDLES)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op_i),
    .type_i    (type_i),
    .value_i   (value_i),
    .result_o  (result_o),
    .fault_o   (fault_o),
    .sw_o      (sw_o),
    .chk_busy  (chk_busy),
    .chk_owner (chk_owner),
    .chk_bound (chk_bound),
    .chk_sw    (chk_sw),
    .chk_res   (chk_res)
);

// File: tb/sim_ehb_table.sv
module sim_ehb_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [1:0]  hnd = 2'd0;
    logic [3:0]  typ = 4'd0;
    logic [31:0] val = 32'd0;
    logic [31:0] result;
    logic        fault, sw;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        flt;
        logic        sw;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc++;

    ehb_table u0 (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .hnd_i(hnd), .type_i(typ),
        .value_i(val), .result_o(result), .fault_o(fault), .sw_o(sw)
    );

    function automatic logic [31:0] enc(input int idx, input int t);
        return (32'(t) << 8) | (32'(idx) << 1);
    endfunction

    task automatic do_op(input logic [2:0] o, input logic [1:0] h, input logic [3:0] t,
                         input logic [31:0] v, input logic [31:0] e_res,
                         input logic e_flt, input logic e_sw, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        op = o; hnd = h; typ = t; val = v;
        e.res = e_res; e.flt = e_flt; e.sw = e_sw; e.due = cyc + 1; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare mid-cycle against the item due in this cycle.
    initial begin
        forever begin
            @(posedge clk);
            #4;
            while (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (result !== e.res || fault !== e.flt || sw !== e.sw) begin
                    fails++;
                    $display("FAIL %s: got res=%h flt=%b sw=%b, exp res=%h flt=%b sw=%b",
                             e.tag, result, fault, sw, e.res, e.flt, e.sw);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #4;
        checks++;
        if (result !== 32'd0 || fault !== 1'b0 || sw !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: got %h/%b/%b, exp 0/0/0", result, fault, sw);
        end
        // Resource types: r0,r1=1  r2,r3=2  r4,r5,r6=3  r7=5
        do_op(3'd3, 2'd0, 4'd0, 32'd0, 32'd0, 1'b1, 1'b0, "R1 save unbound after reset");
        do_op(3'd1, 2'd3, 4'd5, 32'd0, enc(7, 5), 1'b0, 1'b0, "R1 pool free after reset");
        do_op(3'd2, 2'd3, 4'd0, 32'd0, 32'd0, 1'b0, 1'b0, "R4 release h3");
        do_op(3'd1, 2'd0, 4'd1, 32'd0, enc(0, 1), 1'b0, 1'b0, "R2 acquire lowest type1");
        do_op(3'd1, 2'd1, 4'd1, 32'd0, enc(1, 1), 1'b0, 1'b0, "R2 acquire next type1");
        do_op(3'd1, 2'd2, 4'd1, 32'd0, 32'd0, 1'b1, 1'b0, "R3 no free type1");
        do_op(3'd1, 2'd0, 4'd3, 32'd0, 32'd0, 1'b1, 1'b0, "R3 handle already bound");
        do_op(3'd3, 2'd0, 4'd0, 32'd0, enc(0, 1), 1'b0, 1'b0, "R5 save hw h0");
        do_op(3'd2, 2'd1, 4'd0, 32'd0, 32'd0, 1'b0, 1'b0, "R4 release h1");
        do_op(3'd1, 2'd2, 4'd1, 32'd0, enc(1, 1), 1'b0, 1'b0, "R4 freed res1 reused");
        do_op(3'd2, 2'd3, 4'd0, 32'd0, 32'd0, 1'b1, 1'b0, "R4 release unbound h3");
        do_op(3'd4, 2'd3, 4'd0, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0, 1'b1, "R6 sw rebind");
        do_op(3'd3, 2'd3, 4'd0, 32'd0, 32'hDEADBEEF, 1'b0, 1'b1, "R5 save sw h3");
        do_op(3'd4, 2'd3, 4'd0, enc(1, 1), 32'd0, 1'b1, 1'b0, "R7 foreign owner");
        do_op(3'd4, 2'd3, 4'd0, enc(7, 2), 32'd0, 1'b1, 1'b0, "R7 type mismatch");
        do_op(3'd4, 2'd3, 4'd0, enc(8, 5), 32'd0, 1'b1, 1'b0, "R7 index out of range");
        do_op(3'd3, 2'd3, 4'd0, 32'd0, 32'hDEADBEEF, 1'b0, 1'b1, "R9 state kept after faults");
        do_op(3'd4, 2'd3, 4'd0, enc(7, 5), enc(7, 5), 1'b0, 1'b0, "R7 hw rebind accepted");
        do_op(3'd3, 2'd3, 4'd0, 32'd0, enc(7, 5), 1'b0, 1'b0, "R8 sw replaced by hw");
        do_op(3'd4, 2'd0, 4'd0, enc(4, 3), enc(4, 3), 1'b0, 1'b0, "R8 h0 moves to res4");
        do_op(3'd1, 2'd1, 4'd1, 32'd0, enc(0, 1), 1'b0, 1'b0, "R8 old res0 freed");
        do_op(3'd4, 2'd0, 4'd0, enc(4, 3), enc(4, 3), 1'b0, 1'b0, "R7 same owner rebind");
        do_op(3'd4, 2'd1, 4'd0, enc(4, 3), 32'd0, 1'b1, 1'b0, "R7 res4 held by h0");
        do_op(3'd2, 2'd2, 4'd0, 32'd0, 32'd0, 1'b0, 1'b0, "R4 release h2");
        do_op(3'd1, 2'd2, 4'd3, 32'd0, enc(5, 3), 1'b0, 1'b0, "R2 lowest free type3 skips busy");
        do_op(3'd2, 2'd0, 4'd0, 32'd0, 32'd0, 1'b0, 1'b0, "R4 release h0");
        do_op(3'd4, 2'd2, 4'd0, 32'h0000_1235, 32'h0000_1235, 1'b0, 1'b1, "R8 h2 to sw frees res5");
        do_op(3'd1, 2'd0, 4'd3, 32'd0, enc(4, 3), 1'b0, 1'b0, "R2 res4 free again");
        do_op(3'd1, 2'd3, 4'd3, 32'd0, 32'd0, 1'b1, 1'b0, "R3 bound h3 acquire");
        do_op(3'd2, 2'd3, 4'd0, 32'd0, 32'd0, 1'b0, 1'b0, "R4 release h3 res7");
        do_op(3'd1, 2'd3, 4'd3, 32'd0, enc(5, 3), 1'b0, 1'b0, "R8 res5 freed by sw rebind");
        do_op(3'd7, 2'd0, 4'd1, 32'hFFFF_FFFF, 32'd0, 1'b0, 1'b0, "R1 unused code idles");
        do_op(3'd0, 2'd0, 4'd0, 32'd0, 32'd0, 1'b0, 1'b0, "R1 idle");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule